// File: doc/BRIEF.md
# String-to-Port Output Sequencer

This block carries out a memory-to-I/O string transfer for a simple processor datapath. A single start command supplies an opcode, an operand-size flag, an address-size flag, a direction flag, a repeat flag, a count value, a source index and a 16-bit port number. The block then moves one element or a run of elements. For each element it first reads memory at the current source index. It then writes the data to the I/O port and waits for the port's acknowledge. Only after that does it step the index and the count.

The element width is byte, word or doubleword. The index moves by the element width, upward or downward as the direction flag selects. In 16-bit address mode only the low halves of the index and the count take part, and their upper halves pass through unchanged. When the sequence ends, the block presents the final index and count and raises a one-cycle done pulse. The memory and I/O sides never have requests open at the same time, so each I/O write is strictly ordered against the memory reads around it.

Top module: `strout_top`

## Requirements
- R1: After reset, busy, done, memRdReq and ioWrReq are all low.
- R2: Opcode 8'h6E selects a byte element (ioSize 0) whatever opSize32 is. Any other opcode selects a word (ioSize 1) when opSize32 is 0 and a doubleword (ioSize 2) when it is 1. ioData carries the read data with every bit above the element width forced to zero.
- R3: Each element is one memory read at memAddr followed by one I/O write to the latched port number carrying that read's data. memAddr is the full index in 32-bit mode and the zero-extended low 16 bits of the index in 16-bit mode. memRdReq stays high until memRdValid is seen.
- R4: After each acknowledged write, the index moves by 1, 2 or 4 (byte, word, doubleword). It goes up when dirDown is 0 and down when dirDown is 1.
- R5: In 16-bit address mode (addr32 = 0), index arithmetic wraps modulo 65536 and the upper 16 bits of the index are returned unchanged.
- R6: With repeatEn set, the number of elements equals the count, the count drops by one per element and ends at zero. With repeatEn clear, exactly one element moves and the count is returned unchanged.
- R7: In 16-bit address mode only the low 16 bits of the count set the number of elements and are decremented. The upper 16 bits are returned unchanged.
- R8: With repeatEn set and a zero count (as seen in the active address size), no read or write takes place and done rises on the first cycle after the start is accepted.
- R9: ioWrReq stays high until ioAck is seen. No next read and no done occur before that acknowledge.
- R10: memRdReq and ioWrReq are never high together, and a write request only follows a returned read.
- R11: busy is high from the cycle after an accepted start through the done cycle. A start while busy, including one in the done cycle, is ignored.
- R12: done is a single-cycle pulse. In that cycle indexOut and countOut hold the final index and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start command, accepted when idle |
| opcode | input | 8 | String opcode; 8'h6E means byte |
| opSize32 | input | 1 | Operand size: 1 doubleword, 0 word |
| addr32 | input | 1 | Address size: 1 for 32-bit, 0 for 16-bit |
| dirDown | input | 1 | Direction: 1 decrements the index |
| repeatEn | input | 1 | Repeat the transfer count times |
| countIn | input | 32 | Initial count value |
| indexIn | input | 32 | Initial source index |
| portNum | input | 16 | Destination I/O port |
| memRdReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memRdValid | input | 1 | Memory read data valid |
| memRdData | input | 32 | Memory read data |
| ioWrReq | output | 1 | I/O write request |
| ioPort | output | 16 | I/O write port number |
| ioData | output | 32 | I/O write data, masked to size |
| ioSize | output | 2 | Element size code 0/1/2 |
| ioAck | input | 1 | I/O write acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| indexOut | output | 32 | Final source index |
| countOut | output | 32 | Final count |

## Verification
Two events can share a cycle here: the done pulse and a new start request. The bench raises start with fresh parameters exactly in the done cycle. It then checks that busy falls and stays low, and that no memory read starts on the next cycles. This shows the request was dropped and did not slip into the idle state. A second shared cycle is a write request rising in the same cycle its acknowledge comes back. The I/O responder sometimes answers with no delay, and the scoreboard still expects exactly one write per element, in order.

// File: rtl/strout_pkg.sv
package strout_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2
  } elemSize_t;

  typedef struct packed {
    logic load;     // latch the start command
    logic capture;  // latch returned read data
    logic step;     // advance index and count
  } dpCtl_t;

  localparam logic [7:0] OPC_BYTE = 8'h6E;

endpackage

// File: rtl/strout_dp.sv
module strout_dp
  import strout_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int PORT_W  = 16,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [7:0]        opcode,
  input  logic              opSize32,
  input  logic              addr32,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] countIn,
  input  logic [ADDR_W-1:0] indexIn,
  input  logic [PORT_W-1:0] portNum,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PORT_W-1:0] ioPort,
  output logic [DATA_W-1:0] ioData,
  output logic [1:0]        ioSize,
  output logic [ADDR_W-1:0] indexOut,
  output logic [ADDR_W-1:0] countOut,
  output logic              startSkip,
  output logic              lastElem
);

  localparam int HIGH_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] idxQ, cntQ;
  logic [DATA_W-1:0] dataQ;
  logic [PORT_W-1:0] portQ;
  elemSize_t         sizeQ, sizeD;
  logic              wideQ, downQ, repQ;

  logic [ADDR_W-1:0] stepAmt, idxRaw, cntRaw, idxNext, cntNext;

  // Short mode keeps the upper part of the old value.
  function automatic logic [ADDR_W-1:0] mergeShort(
    input logic [ADDR_W-1:0] oldV,
    input logic [ADDR_W-1:0] newV,
    input logic              wide
  );
    if (wide) return newV;
    return {oldV[ADDR_W-1:SHORT_W], newV[SHORT_W-1:0]};
  endfunction

  always_comb begin
    if (opcode == OPC_BYTE)  sizeD = SZ_BYTE;
    else if (opSize32)       sizeD = SZ_DWORD;
    else                     sizeD = SZ_WORD;
  end

  assign startSkip = repeatEn &&
                     (addr32 ? (countIn == '0) : (countIn[SHORT_W-1:0] == '0));

  assign stepAmt = ADDR_W'(1) << sizeQ;
  assign idxRaw  = downQ ? (idxQ - stepAmt) : (idxQ + stepAmt);
  assign cntRaw  = cntQ - ADDR_W'(1);
  assign idxNext = mergeShort(idxQ, idxRaw, wideQ);
  assign cntNext = mergeShort(cntQ, cntRaw, wideQ);

  assign lastElem = !repQ ||
                    (wideQ ? (cntQ == ADDR_W'(1))
                           : (cntQ[SHORT_W-1:0] == SHORT_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ  <= '0;
      cntQ  <= '0;
      dataQ <= '0;
      portQ <= '0;
      sizeQ <= SZ_BYTE;
      wideQ <= 1'b0;
      downQ <= 1'b0;
      repQ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        idxQ  <= indexIn;
        cntQ  <= countIn;
        portQ <= portNum;
        sizeQ <= sizeD;
        wideQ <= addr32;
        downQ <= dirDown;
        repQ  <= repeatEn;
      end
      if (ctl.capture) dataQ <= memRdData;
      if (ctl.step) begin
        idxQ <= idxNext;
        if (repQ) cntQ <= cntNext;
      end
    end
  end

  // Address generation: wide mode or zero-extended low half.
  generate
    if (HIGH_W > 0) begin : g_addrShort
      assign memAddr = wideQ ? idxQ : {{HIGH_W{1'b0}}, idxQ[SHORT_W-1:0]};
    end else begin : g_addrFull
      assign memAddr = idxQ;
    end
  endgenerate

  always_comb begin
    ioData = '0;
    case (sizeQ)
      SZ_BYTE:  ioData[7:0]  = dataQ[7:0];
      SZ_WORD:  ioData[15:0] = dataQ[15:0];
      default:  ioData       = dataQ;
    endcase
  end

  assign ioPort   = portQ;
  assign ioSize   = sizeQ;
  assign indexOut = idxQ;
  assign countOut = cntQ;

endmodule

// File: rtl/strout_ctrl.sv
module strout_ctrl
  import strout_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   startSkip,
  input  logic   lastElem,
  input  logic   memRdValid,
  input  logic   ioAck,
  output dpCtl_t ctl,
  output logic   memRdReq,
  output logic   ioWrReq,
  output logic   busy,
  output logic   done
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } state_t;

  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:  if (start)      stateD = startSkip ? ST_FIN : ST_READ;
      ST_READ:  if (memRdValid) stateD = ST_WRITE;
      ST_WRITE: if (ioAck)      stateD = lastElem ? ST_FIN : ST_READ;
      default:                  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign ctl.load    = (stateQ == ST_IDLE)  && start;
  assign ctl.capture = (stateQ == ST_READ)  && memRdValid;
  assign ctl.step    = (stateQ == ST_WRITE) && ioAck;

  assign memRdReq = (stateQ == ST_READ);
  assign ioWrReq  = (stateQ == ST_WRITE);
  assign busy     = (stateQ != ST_IDLE);
  assign done     = (stateQ == ST_FIN);

endmodule

// File: rtl/strout_top.sv
module strout_top
  import strout_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PORT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic              opSize32,
  input  logic              addr32,
  input  logic              dirDown,
  input  logic              repeatEn,
  input  logic [ADDR_W-1:0] countIn,
  input  logic [ADDR_W-1:0] indexIn,
  input  logic [PORT_W-1:0] portNum,
  output logic              memRdReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRdValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic              ioWrReq,
  output logic [PORT_W-1:0] ioPort,
  output logic [DATA_W-1:0] ioData,
  output logic [1:0]        ioSize,
  input  logic              ioAck,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] indexOut,
  output logic [ADDR_W-1:0] countOut
);

  dpCtl_t ctl;
  logic   startSkip, lastElem;

  strout_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .startSkip  (startSkip),
    .lastElem   (lastElem),
    .memRdValid (memRdValid),
    .ioAck      (ioAck),
    .ctl        (ctl),
    .memRdReq   (memRdReq),
    .ioWrReq    (ioWrReq),
    .busy       (busy),
    .done       (done)
  );

  strout_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PORT_W (PORT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opcode    (opcode),
    .opSize32  (opSize32),
    .addr32    (addr32),
    .dirDown   (dirDown),
    .repeatEn  (repeatEn),
    .countIn   (countIn),
    .indexIn   (indexIn),
    .portNum   (portNum),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .ioPort    (ioPort),
    .ioData    (ioData),
    .ioSize    (ioSize),
    .indexOut  (indexOut),
    .countOut  (countOut),
    .startSkip (startSkip),
    .lastElem  (lastElem)
  );

endmodule

// File: rtl/strout_chk.sv
module strout_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic memRdReq,
  input logic memRdValid,
  input logic ioWrReq,
  input logic ioAck
);

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdReq && ioWrReq)); // R10

  AST_WR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ioWrReq) |-> $past(memRdValid)); // R10

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ioWrReq && !ioAck |=> ioWrReq); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memRdReq && !memRdValid |=> memRdReq); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdReq && !ioWrReq && !done); // R1

endmodule

bind strout_top strout_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busy       (busy),
  .done       (done),
  .memRdReq   (memRdReq),
  .memRdValid (memRdValid),
  .ioWrReq    (ioWrReq),
  .ioAck      (ioAck)
);

// File: tb/test_strout_top.sv
`timescale 1ns/1ps
module test_strout_top;

  typedef struct {
    logic [15:0] port;
    logic [31:0] data;
    logic [1:0]  size;
  } exp_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h6F;
  logic        opSize32 = 1'b0, addr32 = 1'b1, dirDown = 1'b0, repeatEn = 1'b0;
  logic [31:0] countIn = '0, indexIn = '0;
  logic [15:0] portNum = '0;
  logic        memRdReq, ioWrReq, busy, done;
  logic [31:0] memAddr, ioData, indexOut, countOut;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic [15:0] ioPort;
  logic [1:0]  ioSize;
  logic        ioAck = 1'b0;

  int   checks = 0, errors = 0, ordViol = 0, cyc = 0;
  int   rdWait = 0, ackWait = 0;
  exp_t expQ[$];

  always #2 clk = ~clk;

  strout_top i_strout_top (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opSize32(opSize32),
    .addr32(addr32), .dirDown(dirDown), .repeatEn(repeatEn), .countIn(countIn),
    .indexIn(indexIn), .portNum(portNum), .memRdReq(memRdReq), .memAddr(memAddr),
    .memRdValid(memRdValid), .memRdData(memRdData), .ioWrReq(ioWrReq),
    .ioPort(ioPort), .ioData(ioData), .ioSize(ioSize), .ioAck(ioAck),
    .busy(busy), .done(done), .indexOut(indexOut), .countOut(countOut)
  );

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'h0001_0003) ^ 32'hC3A5_5A3C;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory responder
  always @(negedge clk) begin
    if (memRdReq && ioWrReq) ordViol++;
    if (memRdValid) memRdValid = 1'b0;
    else if (memRdReq) begin
      if (rdWait == 0) begin
        memRdValid = 1'b1;
        memRdData  = memFn(memAddr);
        rdWait     = $urandom_range(0, 2);
      end else rdWait--;
    end
  end

  // I/O responder and scoreboard monitor
  always @(negedge clk) begin
    if (ioAck) ioAck = 1'b0;
    else if (ioWrReq) begin
      if (ackWait == 0) begin
        exp_t e;
        ioAck   = 1'b1;
        ackWait = $urandom_range(0, 3);
        if (expQ.size() == 0) begin
          check(1'b0, "R6 unexpected write", {16'h0, ioPort}, 32'h0);
        end else begin
          e = expQ.pop_front();
          check(ioPort == e.port, "R3 port", {16'h0, ioPort}, {16'h0, e.port});
          check(ioData == e.data, "R3 R2 data", ioData, e.data);
          check(ioSize == e.size, "R2 size", {30'h0, ioSize}, {30'h0, e.size});
        end
      end else ackWait--;
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Driver: computes expected writes and final values, runs one command.
  task automatic runXfer(input logic [7:0] opc, input bit s32, input bit a32,
                         input bit down, input bit rep, input logic [31:0] cnt,
                         input logic [31:0] idx, input logic [15:0] port,
                         input bit midStart, input bit doneStart, input string tag);
    logic [1:0]  sz;
    logic [31:0] stepV, x, c, addr, d, nxt;
    int          nElem, waited;
    sz    = (opc == 8'h6E) ? 2'd0 : (s32 ? 2'd2 : 2'd1);
    stepV = 32'd1 << sz;
    nElem = rep ? (a32 ? int'(cnt) : int'(cnt[15:0])) : 1;
    x = idx;
    c = cnt;
    for (int k = 0; k < nElem; k++) begin
      exp_t e;
      addr = a32 ? x : {16'h0, x[15:0]};
      d    = memFn(addr);
      e.port = port;
      e.size = sz;
      e.data = (sz == 2'd0) ? {24'h0, d[7:0]} : (sz == 2'd1) ? {16'h0, d[15:0]} : d;
      expQ.push_back(e);
      nxt = down ? x - stepV : x + stepV;
      x   = a32 ? nxt : {x[31:16], nxt[15:0]};
      if (rep) begin
        nxt = c - 32'd1;
        c   = a32 ? nxt : {c[31:16], nxt[15:0]};
      end
    end

    opcode = opc; opSize32 = s32; addr32 = a32; dirDown = down; repeatEn = rep;
    countIn = cnt; indexIn = idx; portNum = port; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (!done) begin
      @(negedge clk);
      waited++;
      if (midStart && waited == 2) begin
        check(busy == 1'b1, {tag, " R11 busy mid"}, {31'h0, busy}, 32'h1);
        opcode = 8'h6F; opSize32 = 1'b1; addr32 = 1'b1; dirDown = ~down;
        repeatEn = 1'b1; countIn = 32'd9; indexIn = 32'hDEAD_0000;
        portNum = 16'h5555; start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    if (nElem == 0)
      check(waited == 0, {tag, " R8 immediate done"}, waited, 0);
    check(busy == 1'b1, {tag, " R11 busy at done"}, {31'h0, busy}, 32'h1);
    check(expQ.size() == 0, {tag, " R6 R9 writes before done"}, expQ.size(), 0);
    check(indexOut == x, {tag, " R4 R5 index"}, indexOut, x);
    check(countOut == c, {tag, " R6 R7 count"}, countOut, c);
    if (doneStart) begin
      repeatEn = 1'b1; countIn = 32'd5; indexIn = 32'h0; start = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, {tag, " R12 done pulse"}, {31'h0, done}, 32'h0);
    check(busy == 1'b0, {tag, " R11 busy ends"}, {31'h0, busy}, 32'h0);
    @(negedge clk);
    check(!memRdReq && !busy, {tag, " R11 start ignored"}, {30'h0, memRdReq, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !memRdReq && !ioWrReq, "R1 reset",
          {28'h0, busy, done, memRdReq, ioWrReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done, "R1 after release", {30'h0, busy, done}, 32'h0);

    runXfer(8'h6E, 1'b0, 1'b1, 1'b0, 1'b1, 32'd3, 32'h0000_1000, 16'h03F8, 0, 0, "t1 byte up");
    runXfer(8'h6F, 1'b1, 1'b1, 1'b1, 1'b1, 32'd4, 32'h2000_0010, 16'hFFFF, 0, 0, "t2 dword down");
    runXfer(8'h6F, 1'b0, 1'b0, 1'b1, 1'b1, 32'hABCD_0002, 32'h1234_0001, 16'h0080, 0, 0, "t3 R5 wrap down");
    runXfer(8'h6F, 1'b0, 1'b1, 1'b0, 1'b0, 32'd7, 32'h0000_0100, 16'h0001, 0, 0, "t4 single");
    runXfer(8'h6E, 1'b1, 1'b1, 1'b1, 1'b0, 32'd0, 32'h0000_0040, 16'h0000, 0, 0, "t5 R2 byte opc");
    runXfer(8'h6F, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0005_0000, 32'h0000_0200, 16'h0010, 0, 0, "t6 R8 zero");
    runXfer(8'h6F, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_0002, 32'h7777_FFFE, 16'h0020, 0, 0, "t7 R5 wrap up");
    runXfer(8'h6F, 1'b0, 1'b1, 1'b0, 1'b1, 32'd5, 32'h0000_3000, 16'h0030, 1, 0, "t8 R11 mid start");
    runXfer(8'h6E, 1'b0, 1'b1, 1'b0, 1'b1, 32'd2, 32'h0000_4000, 16'h0040, 0, 1, "t9 R11 done start");

    check(ordViol == 0, "R10 ordering", ordViol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule